// File: doc/BRIEF.md
# Priority-Gated Exception Entry and Return Sequencer

This block decides, every clock cycle, whether one of a set of numbered exception requests should interrupt the code that is running. Each request has a priority that software can program. Priority values work in reverse: a lower number means a higher priority. Requests are level inputs, and a single global enable gates all of them. The request that wins arbitration is taken only when its priority value is strictly below the running operating priority. If it is not, it stays pending and is evaluated again on every later cycle.

When a request is taken, the block saves three things on an internal context stack: the interrupted program counter, the mode and the operating priority. It then loads the handler address from a small writable vector table indexed by the exception number. The mode becomes privileged and the operating priority is raised to that of the exception. A return strobe pops the most recent context and restores all three items. Entries can therefore nest up to the stack depth. While the stack is full, a further entry is refused and an overflow flag is raised instead.

Alongside the handler address, the block reports the byte location of the vector slot it used. For exception n, that location is the table base plus (16 + n) × 4.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, pc_load_o = 0, priv_o = 0, ovf_o = 0 and cur_prio_o = 2^PRIO_W (16 by default). 16 is the idle level, and every programmed priority (0 to 15) is higher than it.
- R2: Only requests with req_i[n] = 1 while glb_en_i = 1 take part in arbitration. The winner is the one with the smallest priority value. On equal values, the lowest exception number wins.
- R3: The winner is taken only if its priority value is numerically less than cur_prio_o. Otherwise pc_load_o stays 0 and priv_o and cur_prio_o keep their values.
- R4: One cycle after the edge at which an exception n is taken, pc_load_o is 1 for that one cycle, pc_o holds vector entry n, priv_o = 1 and cur_prio_o holds priority n.
- R5: On entry to exception n, vec_loc_o = TBL_BASE + (16 + n) × 4.
- R6: When ret_i = 1 and the stack is not empty, pc_load_o is 1 one cycle later. At that point pc_o is the pc_i value sampled at the matching entry, and priv_o and cur_prio_o return to their values before that entry.
- R7: Entries nest up to STACK_DEPTH (8) levels deep, and returns restore them in last-in, first-out order.
- R8: While 8 contexts are stacked, a winner that would preempt is refused. The state stays unchanged and ovf_o = 1 in the following cycle, once for each cycle in which this happens. In all other cycles ovf_o = 0.
- R9: When glb_en_i = 0, no request is taken, whatever the state of req_i.
- R10: ret_i with an empty stack has no effect: pc_load_o stays 0 and priv_o and cur_prio_o are unchanged.
- R11: ret_i takes precedence over an entry in the same cycle. A request that is still held is evaluated again against the restored priority in the next cycle.
- R12: A write to the priority table (prio_we_i) or to the vector table (vec_we_i) at index sel takes effect for arbitration and entries from the following cycle on. All table entries reset to priority 15 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global request enable |
| req_i | input | NUM_EXC (12) | Level exception requests, one bit per exception number |
| prio_we_i | input | 1 | Priority table write strobe |
| prio_sel_i | input | IDX_W (4) | Priority table write index |
| prio_wdata_i | input | PRIO_W (4) | Priority value to write |
| vec_we_i | input | 1 | Vector table write strobe |
| vec_sel_i | input | IDX_W (4) | Vector table write index |
| vec_wdata_i | input | ADDR_W (32) | Handler address to write |
| pc_i | input | ADDR_W (32) | Current program counter, saved on entry |
| ret_i | input | 1 | Handler return strobe |
| pc_load_o | output | 1 | One-cycle pulse: load pc_o into the program counter |
| pc_o | output | ADDR_W (32) | New program counter (handler or restored address) |
| vec_loc_o | output | ADDR_W (32) | Byte location of the vector slot used by the last entry |
| priv_o | output | 1 | Privileged-mode flag |
| cur_prio_o | output | PRIO_W+1 (5) | Current operating priority |
| ovf_o | output | 1 | Refused entry because the context stack is full |

## Verification
Every result is registered once. Inputs sampled at clock edge k therefore show up on pc_load_o, pc_o, vec_loc_o, priv_o, cur_prio_o and ovf_o just after edge k, and a table write made at edge k first affects the decision at edge k+1. The bench keeps a reference model. Before each edge it works out the model's outcome from the inputs it has just driven, then compares the outputs 1 ns after that edge, and only then drives the next inputs. pc_o and vec_loc_o are compared only in cycles where a load is expected, because between loads they only hold their last value.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int ADDR_W = 32;
  localparam int PRIO_W = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] pc;
    logic              priv;
    logic [PRIO_W:0]   prio;
  } ctx_t;
endpackage

// File: rtl/exc_tables.sv
module exc_tables
  import exc_pkg::*;
#(
  parameter int NUM_EXC = 12,
  localparam int IDX_W = $clog2(NUM_EXC)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              prio_we_i,
  input  logic [IDX_W-1:0]                  prio_sel_i,
  input  logic [PRIO_W-1:0]                 prio_wdata_i,
  input  logic                              vec_we_i,
  input  logic [IDX_W-1:0]                  vec_sel_i,
  input  logic [ADDR_W-1:0]                 vec_wdata_i,
  output logic [NUM_EXC-1:0][PRIO_W-1:0]    prio_o,
  output logic [NUM_EXC-1:0][ADDR_W-1:0]    vec_o
);
  for (genvar g = 0; g < NUM_EXC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[g] <= '1;
        vec_o[g]  <= '0;
      end else begin
        if (prio_we_i && prio_sel_i == IDX_W'(g)) prio_o[g] <= prio_wdata_i;
        if (vec_we_i && vec_sel_i == IDX_W'(g))   vec_o[g]  <= vec_wdata_i;
      end
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NUM_EXC = 12,
  localparam int IDX_W = $clog2(NUM_EXC)
) (
  input  logic [NUM_EXC-1:0]             req_i,
  input  logic [NUM_EXC-1:0][PRIO_W-1:0] prio_i,
  output logic                           valid_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [PRIO_W-1:0]              prio_o
);
  // strict compare keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < NUM_EXC; i++) begin
      if (req_i[i] && (!valid_o || prio_i[i] < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack
  import exc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  ctx_t din_i,
  output ctx_t dout_o,
  output logic full_o,
  output logic empty_o
);
  ctx_t             mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] top_idx;

  assign top_idx = PTR_W'(cnt_q - CNT_W'(1));
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[top_idx];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[PTR_W'(cnt_q)] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (push_i) cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  // R8
  push_not_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R10
  pop_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R7
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int                NUM_EXC     = 12,
  parameter int                STACK_DEPTH = 8,
  parameter logic [ADDR_W-1:0] TBL_BASE    = '0,
  localparam int IDX_W = $clog2(NUM_EXC),
  localparam int CUR_W = PRIO_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic [NUM_EXC-1:0] req_i,
  input  logic               prio_we_i,
  input  logic [IDX_W-1:0]   prio_sel_i,
  input  logic [PRIO_W-1:0]  prio_wdata_i,
  input  logic               vec_we_i,
  input  logic [IDX_W-1:0]   vec_sel_i,
  input  logic [ADDR_W-1:0]  vec_wdata_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               ret_i,
  output logic               pc_load_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [ADDR_W-1:0]  vec_loc_o,
  output logic               priv_o,
  output logic [CUR_W-1:0]   cur_prio_o,
  output logic               ovf_o
);
  localparam logic [CUR_W-1:0] IDLE_PRIO = CUR_W'(1 << PRIO_W);
  localparam logic [ADDR_W-1:0] SLOT_OFS = ADDR_W'(16);

  logic [NUM_EXC-1:0][PRIO_W-1:0] prio_tbl;
  logic [NUM_EXC-1:0][ADDR_W-1:0] vec_tbl;
  logic [NUM_EXC-1:0]             req_en;
  logic                           win_valid;
  logic [IDX_W-1:0]               win_idx;
  logic [PRIO_W-1:0]              win_prio;
  logic                           take, do_push, do_pop;
  logic                           stk_full, stk_empty;
  ctx_t                           push_ctx, top_ctx;

  exc_tables #(.NUM_EXC(NUM_EXC)) u_tables (
    .clk_i, .rst_ni,
    .prio_we_i, .prio_sel_i, .prio_wdata_i,
    .vec_we_i, .vec_sel_i, .vec_wdata_i,
    .prio_o(prio_tbl), .vec_o(vec_tbl)
  );

  assign req_en = req_i & {NUM_EXC{glb_en_i}};

  exc_arbiter #(.NUM_EXC(NUM_EXC)) u_arb (
    .req_i(req_en), .prio_i(prio_tbl),
    .valid_o(win_valid), .idx_o(win_idx), .prio_o(win_prio)
  );

  // return wins over entry in the same cycle
  assign take    = !ret_i && win_valid && ({1'b0, win_prio} < cur_prio_o);
  assign do_push = take && !stk_full;
  assign do_pop  = ret_i && !stk_empty;

  assign push_ctx = '{pc: pc_i, priv: priv_o, prio: cur_prio_o};

  ctx_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i, .rst_ni,
    .push_i(do_push), .pop_i(do_pop),
    .din_i(push_ctx), .dout_o(top_ctx),
    .full_o(stk_full), .empty_o(stk_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_load_o  <= 1'b0;
      pc_o       <= '0;
      vec_loc_o  <= '0;
      priv_o     <= 1'b0;
      cur_prio_o <= IDLE_PRIO;
      ovf_o      <= 1'b0;
    end else begin
      pc_load_o <= do_push || do_pop;
      ovf_o     <= take && stk_full;
      if (do_pop) begin
        pc_o       <= top_ctx.pc;
        priv_o     <= top_ctx.priv;
        cur_prio_o <= top_ctx.prio;
      end else if (do_push) begin
        pc_o       <= vec_tbl[win_idx];
        vec_loc_o  <= TBL_BASE + ((SLOT_OFS + ADDR_W'(win_idx)) << 2);
        priv_o     <= 1'b1;
        cur_prio_o <= {1'b0, win_prio};
      end
    end
  end

  // R1
  idle_unpriv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_prio_o == IDLE_PRIO) |-> !priv_o);
  // R3
  prio_raise_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_prio_o < $past(cur_prio_o)) |-> priv_o);
  // R9
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i && !ret_i) |=> ($stable(cur_prio_o) && !pc_load_o));
  // R10
  empty_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && stk_empty) |=> (!pc_load_o && $stable(cur_prio_o)));
  // R2
  winner_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> (req_i[win_idx] && glb_en_i));
  // R8
  ovf_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !pc_load_o);
endmodule

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
  localparam int NUM = 12;
  localparam int DEP = 8;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [NUM-1:0] req = '0;
  logic        pwe = 1'b0, vwe = 1'b0, ret = 1'b0;
  logic [3:0]  psel = '0, vsel = '0, pdata = '0;
  logic [31:0] vdata = '0, pc = '0;
  logic        pc_load, priv, ovf;
  logic [31:0] pc_out, vloc;
  logic [4:0]  cur;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl #(.NUM_EXC(NUM), .STACK_DEPTH(DEP), .TBL_BASE(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(en), .req_i(req),
    .prio_we_i(pwe), .prio_sel_i(psel), .prio_wdata_i(pdata),
    .vec_we_i(vwe), .vec_sel_i(vsel), .vec_wdata_i(vdata),
    .pc_i(pc), .ret_i(ret),
    .pc_load_o(pc_load), .pc_o(pc_out), .vec_loc_o(vloc),
    .priv_o(priv), .cur_prio_o(cur), .ovf_o(ovf)
  );

  // reference model
  int          m_prio [NUM];
  logic [31:0] m_vec  [NUM];
  int          m_cur, m_dep;
  bit          m_priv;
  logic [31:0] s_pc   [DEP];
  bit          s_priv [DEP];
  int          s_prio [DEP];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pick_winner();
    int w = -1;
    if (en)
      for (int i = 0; i < NUM; i++)
        if (req[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
    return w;
  endfunction

  task automatic cycle(input string tag);
    bit e_load = 0, e_ovf = 0, e_ent = 0;
    logic [31:0] e_pc = '0, e_loc = '0;
    int w;
    if (ret) begin
      if (m_dep > 0) begin
        m_dep--;
        e_pc = s_pc[m_dep]; m_priv = s_priv[m_dep]; m_cur = s_prio[m_dep];
        e_load = 1;
      end
    end else begin
      w = pick_winner();
      if (w >= 0 && m_prio[w] < m_cur) begin
        if (m_dep == DEP) e_ovf = 1;
        else begin
          s_pc[m_dep] = pc; s_priv[m_dep] = m_priv; s_prio[m_dep] = m_cur;
          m_dep++;
          e_pc = m_vec[w]; e_loc = BASE + 32'((16 + w) * 4);
          m_priv = 1; m_cur = m_prio[w];
          e_load = 1; e_ent = 1;
        end
      end
    end
    if (pwe) m_prio[psel] = int'(pdata);
    if (vwe) m_vec[vsel] = vdata;
    @(posedge clk); #1;
    chk({tag, " load"}, 64'(pc_load), 64'(e_load));
    if (e_load) chk(e_ent ? "R4 pc" : "R6 pc", 64'(pc_out), 64'(e_pc));
    if (e_ent) chk("R5 vec_loc", 64'(vloc), 64'(e_loc));
    chk({tag, " priv"}, 64'(priv), 64'(m_priv));
    chk({tag, " prio"}, 64'(cur), 64'(m_cur));
    chk("R8 ovf", 64'(ovf), 64'(e_ovf));
    pwe = 0; vwe = 0; ret = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NUM; i++) begin m_prio[i] = 15; m_vec[i] = '0; end
    m_cur = 16; m_dep = 0; m_priv = 0;
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 load", 64'(pc_load), 64'd0);
    chk("R1 priv", 64'(priv), 64'd0);
    chk("R1 prio", 64'(cur), 64'd16);
    chk("R1 ovf", 64'(ovf), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 prio after release", 64'(cur), 64'd16);
    en = 1'b1;

    // R12: program tables
    for (int i = 0; i < NUM; i++) begin
      vwe = 1; vsel = 4'(i); vdata = 32'h8000_0000 + 32'(i * 32'h100);
      pc = 32'h100 + 32'(i);
      cycle("R12");
    end
    pwe = 1; psel = 4'd3; pdata = 4'd2; cycle("R12");
    pwe = 1; psel = 4'd5; pdata = 4'd2; cycle("R12");
    pwe = 1; psel = 4'd1; pdata = 4'd5; cycle("R12");
    pwe = 1; psel = 4'd6; pdata = 4'd0; cycle("R12");

    // R2: tie on priority 2, lowest number wins
    req = 12'b0000_0010_1000; pc = 32'h200; cycle("R2");
    req = '0;
    // R3: priority 5 cannot preempt level 2
    req = 12'b0000_0000_0010; pc = 32'h204; cycle("R3");
    cycle("R3");
    // R7: priority 0 nests
    req = 12'b0000_0100_0010; pc = 32'h208; cycle("R7");
    req = 12'b0000_0000_0010;
    ret = 1; cycle("R6");
    // R11: return then held request re-evaluated at idle
    ret = 1; cycle("R11");
    cycle("R11");
    req = '0; ret = 1; cycle("R6");
    // R10: return with empty stack
    ret = 1; cycle("R10");
    // R9: global enable off
    en = 0; req = 12'hFFF; cycle("R9"); cycle("R9");
    en = 1; req = '0;
    // R12: write and request in the same cycle uses the old value
    pwe = 1; psel = 4'd2; pdata = 4'd1; req = 12'b0000_0000_0100; cycle("R12");
    req = '0; ret = 1; cycle("R6");

    // R8: fill the stack with strictly rising priorities
    for (int i = 0; i < NUM; i++) begin
      pwe = 1; psel = 4'(i); pdata = 4'(11 - i); cycle("R12");
    end
    for (int k = 0; k < 9; k++) begin
      req[k] = 1'b1; pc = 32'h300 + 32'(k * 4); cycle("R8");
    end
    cycle("R8");
    req = '0;
    for (int k = 0; k < 8; k++) begin ret = 1; cycle("R7"); end
    ret = 1; cycle("R10");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      req = NUM'($urandom & $urandom & $urandom);
      en = ($urandom % 10) != 0;
      ret = ($urandom % 4) == 0;
      pc = $urandom;
      if ($urandom % 8 == 0) begin pwe = 1; psel = 4'($urandom % NUM); pdata = 4'($urandom); end
      if ($urandom % 8 == 0) begin vwe = 1; vsel = 4'($urandom % NUM); vdata = $urandom; end
      cycle("R3");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule